// File: doc/BRIEF.md
# Edge-Interrupt GPIO Port Controller

This block is one general-purpose I/O port with a configurable number of pins (16 for a full port, 14 for a reduced one). Software reaches it through a small word-addressed register port: it chooses each pin's direction, loads an output latch, and reads the pin levels back after a two-flop synchronizer. Dedicated write-only set and clear registers change single latch bits in one write, with no read-modify-write.

Every pin can raise an interrupt on a rising edge, a falling edge, or both. Edges are taken from the synchronized pad level, so a pin that the port drives itself still produces events. Each event sets a sticky pending bit. Software clears a pending bit by writing a 1 to it. One interrupt line stays high while any pending bit is set.

A per-pin select input gives a pin to a peripheral. The peripheral's data and output-enable then drive the pad in place of the port registers. The port can still read the pin's level.

Top module: `irq_gpio_port`

## Requirements
- R1: After reset every register reads zero, `pad_oe` is all zero and `irq` is low.
- R2: Word offset 0 holds the direction (1 = output) and reads back. One cycle after a write, `pad_oe` matches it on every pin whose `perip_sel` bit is 0.
- R3: Word offset 1 holds the output latch and reads back. Its value reaches the pad only on pins whose direction bit is 1. Pins whose direction bit is 0 show the externally driven level.
- R4: Word offset 2 is read-only and returns the synchronized pin level, including on pins in peripheral mode.
- R5: A 0-to-1 pin transition sets that pin's pending bit (offset 5) when its rising-enable bit (offset 4) is 1, and has no effect when the bit is 0. Pending bits stay set until cleared.
- R6: A 1-to-0 pin transition sets that pin's pending bit when its falling-enable bit (offset 3) is 1. A rising transition on a pin that has only falling detection enabled leaves the pending bit at 0.
- R7: Edge detection also works on pins configured as outputs, when the edge comes from the port's own latch through the pad.
- R8: Writing offset 5 clears each pending bit written with 1. Bits written with 0 are unchanged.
- R9: `irq` is high exactly while at least one pending bit is set.
- R10: Writing offset 6 sets the latch bits at the 1 positions of the written data and leaves the other bits unchanged. Offset 6 reads as zero.
- R11: Writing offset 7 clears the latch bits at the 1 positions of the written data and leaves the other bits unchanged. Offset 7 reads as zero.
- R12: When an edge event and a clearing write hit the same pending bit in the same cycle, the bit ends up set.
- R13: While a pin's `perip_sel` bit is 1, `pad_out` and `pad_oe` for that pin follow `perip_out` and `perip_oe` one cycle later.
- R14: Offsets 8 and above read as zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Register word address |
| bus_wr | input | 1 | Write strobe for the current address |
| bus_wdata | input | WIDTH | Write data |
| bus_rdata | output | WIDTH | Read data, registered one cycle after the address |
| pin_in | input | WIDTH | Pad level, asynchronous |
| pad_out | output | WIDTH | Pad output data |
| pad_oe | output | WIDTH | Pad output enable |
| perip_sel | input | WIDTH | Per-pin handover to a peripheral |
| perip_out | input | WIDTH | Peripheral output data |
| perip_oe | input | WIDTH | Peripheral output enable |
| irq | output | 1 | Interrupt request, OR of the pending bits |

## Verification
The bench builds the block with WIDTH = 14, ADDR_W = 4 and SYNC_STAGES = 2. This makes it the reduced port and checks that the top pin (bit 13) and all-ones patterns stay inside the register width. The four address bits give eight offsets past the register page, which exercises the zero-read and ignored-write rules. With a two-stage synchronizer, the edge timing is known to the exact cycle, so the bench can place a clearing write in the same cycle as a new edge event. A loopback model on the pads feeds output pins back into the edge detector.

// File: rtl/irq_gpio_pkg.sv
package irq_gpio_pkg;
  // Word offsets inside the register page; software decodes these.
  typedef enum logic [2:0] {
    OFF_DIR  = 3'd0,
    OFF_OUT  = 3'd1,
    OFF_IN   = 3'd2,
    OFF_FEN  = 3'd3,
    OFF_REN  = 3'd4,
    OFF_PEND = 3'd5,
    OFF_SET  = 3'd6,
    OFF_CLR  = 3'd7
  } reg_off_e;

  localparam int OFF_W = 3;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH  = 16,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [STAGES-1:0][WIDTH-1:0] stage_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_q <= '0;
    end else begin
      stage_q[0] <= async_in;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_edge_pend.sv
module gpio_edge_pend #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] lvl,
  input  logic [WIDTH-1:0] rise_en,
  input  logic [WIDTH-1:0] fall_en,
  input  logic             clr_wr,
  input  logic [WIDTH-1:0] clr_mask,
  output logic [WIDTH-1:0] edge_hit,
  output logic [WIDTH-1:0] pend,
  output logic             irq
);
  logic [WIDTH-1:0] prev_q;
  logic [WIDTH-1:0] pend_q;
  logic [WIDTH-1:0] pend_next;
  logic             irq_q;

  always_comb begin
    edge_hit  = (lvl & ~prev_q & rise_en) | (~lvl & prev_q & fall_en);
    // A fresh event outranks a same-cycle clear.
    pend_next = (pend_q & ~(clr_wr ? clr_mask : '0)) | edge_hit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= '0;
      pend_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      prev_q <= lvl;
      pend_q <= pend_next;
      irq_q  <= |pend_next;
    end
  end

  assign pend = pend_q;
  assign irq  = irq_q;
endmodule

// File: rtl/gpio_out_drive.sv
module gpio_out_drive #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_data,
  input  logic             wr_set,
  input  logic             wr_clr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [WIDTH-1:0] ddr,
  input  logic [WIDTH-1:0] perip_sel,
  input  logic [WIDTH-1:0] perip_out,
  input  logic [WIDTH-1:0] perip_oe,
  output logic [WIDTH-1:0] odata,
  output logic [WIDTH-1:0] pad_out,
  output logic [WIDTH-1:0] pad_oe
);
  logic [WIDTH-1:0] odata_q;

  always_ff @(posedge clk) begin
    if (rst)          odata_q <= '0;
    else if (wr_data) odata_q <= wdata;
    else if (wr_set)  odata_q <= odata_q | wdata;
    else if (wr_clr)  odata_q <= odata_q & ~wdata;
  end

  for (genvar g = 0; g < WIDTH; g++) begin : g_pad
    always_ff @(posedge clk) begin
      if (rst) begin
        pad_out[g] <= 1'b0;
        pad_oe[g]  <= 1'b0;
      end else if (perip_sel[g]) begin
        pad_out[g] <= perip_out[g];
        pad_oe[g]  <= perip_oe[g];
      end else begin
        pad_out[g] <= odata_q[g];
        pad_oe[g]  <= ddr[g];
      end
    end
  end

  assign odata = odata_q;
endmodule

// File: rtl/irq_gpio_port.sv
module irq_gpio_port
  import irq_gpio_pkg::*;
#(
  parameter int WIDTH       = 16,
  parameter int ADDR_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [WIDTH-1:0]  bus_wdata,
  output logic [WIDTH-1:0]  bus_rdata,
  input  logic [WIDTH-1:0]  pin_in,
  output logic [WIDTH-1:0]  pad_out,
  output logic [WIDTH-1:0]  pad_oe,
  input  logic [WIDTH-1:0]  perip_sel,
  input  logic [WIDTH-1:0]  perip_out,
  input  logic [WIDTH-1:0]  perip_oe,
  output logic              irq
);
  logic       in_page;
  reg_off_e   off;
  logic       wr_dir, wr_out, wr_fen, wr_ren, wr_pend, wr_set, wr_clr;

  logic [WIDTH-1:0] ddr_q, fen_q, ren_q;
  logic [WIDTH-1:0] lvl, edge_hit, pend_q, odata_q;
  logic [WIDTH-1:0] rd_next, rdata_q;

  assign in_page = (bus_addr >> OFF_W) == '0;
  assign off     = reg_off_e'(bus_addr[OFF_W-1:0]);

  always_comb begin
    wr_dir  = bus_wr && in_page && (off == OFF_DIR);
    wr_out  = bus_wr && in_page && (off == OFF_OUT);
    wr_fen  = bus_wr && in_page && (off == OFF_FEN);
    wr_ren  = bus_wr && in_page && (off == OFF_REN);
    wr_pend = bus_wr && in_page && (off == OFF_PEND);
    wr_set  = bus_wr && in_page && (off == OFF_SET);
    wr_clr  = bus_wr && in_page && (off == OFF_CLR);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ddr_q <= '0;
      fen_q <= '0;
      ren_q <= '0;
    end else begin
      if (wr_dir) ddr_q <= bus_wdata;
      if (wr_fen) fen_q <= bus_wdata;
      if (wr_ren) ren_q <= bus_wdata;
    end
  end

  gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in (pin_in),
    .sync_out (lvl)
  );

  gpio_edge_pend #(.WIDTH(WIDTH)) u_pend (
    .clk      (clk),
    .rst      (rst),
    .lvl      (lvl),
    .rise_en  (ren_q),
    .fall_en  (fen_q),
    .clr_wr   (wr_pend),
    .clr_mask (bus_wdata),
    .edge_hit (edge_hit),
    .pend     (pend_q),
    .irq      (irq)
  );

  gpio_out_drive #(.WIDTH(WIDTH)) u_out (
    .clk       (clk),
    .rst       (rst),
    .wr_data   (wr_out),
    .wr_set    (wr_set),
    .wr_clr    (wr_clr),
    .wdata     (bus_wdata),
    .ddr       (ddr_q),
    .perip_sel (perip_sel),
    .perip_out (perip_out),
    .perip_oe  (perip_oe),
    .odata     (odata_q),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe)
  );

  always_comb begin
    rd_next = '0;
    if (in_page) begin
      case (off)
        OFF_DIR:  rd_next = ddr_q;
        OFF_OUT:  rd_next = odata_q;
        OFF_IN:   rd_next = lvl;
        OFF_FEN:  rd_next = fen_q;
        OFF_REN:  rd_next = ren_q;
        OFF_PEND: rd_next = pend_q;
        default:  rd_next = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= rd_next;
  end

  assign bus_rdata = rdata_q;
endmodule

// File: rtl/irq_gpio_port_chk.sv
module irq_gpio_port_chk
  import irq_gpio_pkg::*;
#(
  parameter int WIDTH  = 16,
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [WIDTH-1:0]  bus_wdata,
  input logic [WIDTH-1:0]  edge_hit,
  input logic [WIDTH-1:0]  pend,
  input logic [WIDTH-1:0]  odata,
  input logic              irq
);
  logic hit_pend, hit_set, hit_clr;
  assign hit_pend = bus_wr && (bus_addr == ADDR_W'(OFF_PEND));
  assign hit_set  = bus_wr && (bus_addr == ADDR_W'(OFF_SET));
  assign hit_clr  = bus_wr && (bus_addr == ADDR_W'(OFF_CLR));

  p_reset_clean_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!irq && pend == '0 && odata == '0));

  p_sticky_r5: assert property (@(posedge clk) disable iff (rst)
    !hit_pend |=> ((pend & $past(pend)) == $past(pend)));

  p_w1c_r8: assert property (@(posedge clk) disable iff (rst)
    (hit_pend && edge_hit == '0) |=> ((pend & $past(bus_wdata)) == '0));

  p_irq_or_r9: assert property (@(posedge clk) disable iff (rst)
    irq == (pend != '0));

  p_set_mask_r10: assert property (@(posedge clk) disable iff (rst)
    hit_set |=> ((odata & $past(bus_wdata)) == $past(bus_wdata)));

  p_clr_mask_r11: assert property (@(posedge clk) disable iff (rst)
    hit_clr |=> ((odata & $past(bus_wdata)) == '0));

  p_event_wins_r12: assert property (@(posedge clk) disable iff (rst)
    (edge_hit != '0) |=> ((pend & $past(edge_hit)) == $past(edge_hit)));
endmodule

bind irq_gpio_port irq_gpio_port_chk #(.WIDTH(WIDTH), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .edge_hit  (edge_hit),
  .pend      (pend_q),
  .odata     (odata_q),
  .irq       (irq)
);

// File: tb/sim_irq_gpio_port.sv
module sim_irq_gpio_port;
  localparam int W  = 14;
  localparam int AW = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] bus_addr = '0;
  logic          bus_wr = 1'b0;
  logic [W-1:0]  bus_wdata = '0;
  logic [W-1:0]  bus_rdata;
  logic [W-1:0]  pin_in, pad_out, pad_oe;
  logic [W-1:0]  perip_sel = '0, perip_out = '0, perip_oe = '0;
  logic [W-1:0]  ext = '0;
  logic          irq;

  int checks = 0;
  int fails  = 0;
  logic done = 1'b0;

  always #2 clk = ~clk;

  // Pad loopback: a driven pad shows its own value, otherwise the outside level.
  assign pin_in = (pad_oe & pad_out) | (~pad_oe & ext);

  irq_gpio_port #(.WIDTH(W), .ADDR_W(AW), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .perip_sel(perip_sel),
    .perip_out(perip_out), .perip_oe(perip_oe), .irq(irq)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [W-1:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = AW'(a); bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int a, output logic [W-1:0] d);
    @(negedge clk);
    bus_addr = AW'(a);
    @(posedge clk);
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [W-1:0] v;
    for (int a = 0; a < 8; a++) begin
      rd(a, v);
      chk("R1 register reset", v, '0);
    end
    chk("R1 pad_oe reset", pad_oe, '0);
    chk("R1 irq reset", {{(W-1){1'b0}}, irq}, '0);
  endtask

  task automatic t_dir;
    logic [W-1:0] v;
    wr(0, 14'h3FFF);
    rd(0, v);
    chk("R2 direction readback all ones", v, 14'h3FFF);
    wr(0, 14'h2A5A);
    rd(0, v);
    chk("R2 direction readback", v, 14'h2A5A);
    chk("R2 pad_oe follows direction", pad_oe, 14'h2A5A);
    wr(0, 14'h00FF);
  endtask

  task automatic t_out;
    logic [W-1:0] v;
    ext = 14'h3F00;
    wr(1, 14'h1234);
    rd(1, v);
    chk("R3 output latch readback", v, 14'h1234);
    idle(5);
    rd(2, v);
    chk("R3 R4 pin levels only outputs driven", v, 14'h3F34);
    chk("R3 pad_out carries latch", pad_out, 14'h1234);
    ext = '0;
  endtask

  task automatic t_setclr;
    logic [W-1:0] v;
    wr(1, 14'h0F0F);
    wr(6, 14'h3000);
    rd(1, v);
    chk("R10 set mask", v, 14'h3F0F);
    wr(7, 14'h0103);
    rd(1, v);
    chk("R11 clear mask", v, 14'h3E0C);
    rd(6, v);
    chk("R10 set mask reads zero", v, '0);
    rd(7, v);
    chk("R11 clear mask reads zero", v, '0);
    wr(1, '0);
    wr(0, '0);
    idle(5);
  endtask

  task automatic t_rise;
    logic [W-1:0] v;
    wr(4, 14'h0004);
    ext = 14'h000C;
    idle(5);
    rd(5, v);
    chk("R5 rising edge sets only enabled bit", v, 14'h0004);
    chk("R9 irq high with pending", {{(W-1){1'b0}}, irq}, 14'h0001);
    idle(4);
    rd(5, v);
    chk("R5 pending is sticky", v, 14'h0004);
  endtask

  task automatic t_fall;
    logic [W-1:0] v;
    wr(3, 14'h0020);
    ext = ext | 14'h0020;
    idle(5);
    rd(5, v);
    chk("R6 rise on fall-only pin ignored", v, 14'h0004);
    ext = ext & ~14'h0020;
    idle(5);
    rd(5, v);
    chk("R6 falling edge sets pending", v, 14'h0024);
  endtask

  task automatic t_w1c;
    logic [W-1:0] v;
    wr(5, 14'h0000);
    rd(5, v);
    chk("R8 zero write leaves pending", v, 14'h0024);
    wr(5, 14'h0004);
    rd(5, v);
    chk("R8 one clears bit", v, 14'h0020);
    chk("R9 irq holds with bit left", {{(W-1){1'b0}}, irq}, 14'h0001);
    wr(5, 14'h0020);
    chk("R9 irq drops when all clear", {{(W-1){1'b0}}, irq}, '0);
    rd(5, v);
    chk("R8 all cleared", v, '0);
  endtask

  task automatic t_output_edge;
    logic [W-1:0] v;
    wr(0, 14'h2080);
    wr(4, 14'h2080);
    wr(6, 14'h2080);
    idle(6);
    rd(5, v);
    chk("R7 edge on driven output pins incl bit 13", v, 14'h2080);
    wr(5, 14'h2080);
    wr(4, '0);
    wr(7, 14'h2080);
    wr(0, '0);
    idle(5);
  endtask

  task automatic t_collision;
    logic [W-1:0] v;
    wr(4, 14'h0200);
    ext = ext | 14'h0200;
    idle(5);
    ext = ext & ~14'h0200;
    idle(5);
    rd(5, v);
    chk("R12 setup pending", v, 14'h0200);
    @(negedge clk); ext = ext | 14'h0200;
    @(posedge clk);
    @(negedge clk);
    @(posedge clk);
    @(negedge clk); bus_wr = 1'b1; bus_addr = AW'(5); bus_wdata = 14'h0200;
    @(posedge clk);
    @(negedge clk); bus_wr = 1'b0;
    rd(5, v);
    chk("R12 event wins over clear", v, 14'h0200);
    wr(5, 14'h0200);
    rd(5, v);
    chk("R12 later clear works", v, '0);
    wr(4, '0);
  endtask

  task automatic t_perip;
    logic [W-1:0] v;
    @(negedge clk);
    perip_sel = 14'h0800; perip_oe = 14'h0800; perip_out = 14'h0800;
    idle(2);
    chk("R13 perip drives pad_oe", pad_oe, 14'h0800);
    chk("R13 perip drives pad_out", pad_out, 14'h0800);
    idle(4);
    rd(2, v);
    chk("R4 pin readable in peripheral mode", v & 14'h0800, 14'h0800);
    @(negedge clk); perip_out = '0;
    idle(2);
    chk("R13 pad_out follows peripheral", pad_out & 14'h0800, '0);
    @(negedge clk); perip_sel = '0; perip_oe = '0;
    idle(2);
  endtask

  task automatic t_unused;
    logic [W-1:0] v;
    wr(9, 14'h1111);
    wr(8, 14'h2222);
    for (int a = 8; a < 16; a++) begin
      rd(a, v);
      chk("R14 offset past page reads zero", v, '0);
    end
    rd(1, v);
    chk("R14 write past page ignored (latch)", v, '0);
    rd(0, v);
    chk("R14 write past page ignored (direction)", v, '0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    t_reset();
    t_dir();
    t_out();
    t_setclr();
    t_rise();
    t_fall();
    t_w1c();
    t_output_edge();
    t_collision();
    t_perip();
    t_unused();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule